// File: doc/BRIEF.md
# I/O Window Address Translator

This block sits behind the host bridge's CPU-side decoder. It turns each CPU access that lands in the bridge's I/O window into an access on the PCI I/O address space. The window begins at a parameterised CPU base address, `0x8000_0000` by default, which must be aligned to the 8 MiB span. The block subtracts the base to get a window offset. It then forms a 16-bit PCI I/O address in one of two ways, chosen by the `sparse_mode` level input.

In the flat layout, the low 16 bits of the offset are used directly. In the sparse layout, each 32-byte group of I/O ports occupies the start of its own 4 KiB CPU page across the 8 MiB window. This lets software protect ranges of ports page by page. Offset bits 22:12 become PCI address bits 15:5, offset bits 4:0 are kept, and offset bits 11:5 are dropped.

Every access is 1, 2 or 4 bytes, little-endian, and may be unaligned. The translated access is registered and issued one cycle later with a valid strobe. An illegal size gives an error pulse instead. Read data from the PCI side comes back one cycle after its strobe, zero-extended to the width of the last read that was issued.

Top module: `iowin_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `io_valid`, `io_err` and `cpu_rready` are 0.
- R2: With `sparse_mode` = 0, `io_addr` equals bits 15:0 of the window offset (`cpu_addr` minus the base).
- R3: With `sparse_mode` = 1, `io_addr` bits 15:5 equal offset bits 22:12, and `io_addr` bits 4:0 equal offset bits 4:0.
- R4: With `sparse_mode` = 1, two offsets that differ only in bits 11:5 produce the same `io_addr`.
- R5: Each access uses the value of `sparse_mode` in the cycle when `cpu_req` is high. A mode change between two back-to-back accesses affects only the second one.
- R6: A request with `cpu_size` of 1, 2 or 4 (a byte count) raises `io_valid` for exactly one cycle, in the cycle after `cpu_req`. In that cycle `io_size` and `io_we` equal the request's values.
- R7: A request with any other `cpu_size` value (0, 3, 5, 6 or 7) raises `io_err` for one cycle in the cycle after `cpu_req`, and `io_valid` stays 0 in that cycle.
- R8: No alignment check is made. For example, a 4-byte access at offset 3 is forwarded with `io_addr` bits 1:0 equal to 3.
- R9: `io_wdata` carries the low `cpu_size` bytes of `cpu_wdata` in little-endian lanes, and the higher bytes are 0.
- R10: One cycle after `io_rvalid`, `cpu_rready` is 1 for one cycle. At the same time `cpu_rdata` equals `io_rdata`, keeping only the low bytes given by the size of the most recent legal read issued, with the other bytes set to 0.
- R11: In a cycle that follows a cycle without `cpu_req`, both `io_valid` and `io_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access strobe for the window |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 3 | Access size in bytes |
| cpu_wdata | input | 32 | Write data, little-endian lanes |
| sparse_mode | input | 1 | 0 = flat 64 KiB, 1 = sparse 8 MiB |
| io_valid | output | 1 | Translated access strobe |
| io_we | output | 1 | Translated write flag |
| io_addr | output | 16 | PCI I/O address |
| io_size | output | 3 | Translated size in bytes |
| io_wdata | output | 32 | Masked write data |
| io_err | output | 1 | Illegal-size pulse |
| io_rvalid | input | 1 | Read data strobe from the PCI side |
| io_rdata | input | 32 | Read data from the PCI side |
| cpu_rready | output | 1 | Read return strobe |
| cpu_rdata | output | 32 | Zero-extended read data |

## Verification
The bench builds the block with its default parameters:
- a window base of `0x8000_0000`, so the base subtraction is exercised;
- an 8 MiB span with 4 KiB pages and 32-byte groups, so the top page and the all-ones sparse address `0xFFFF` are reachable;
- a 32-bit data path, so byte, halfword and word accesses all occur.

With these values the bench can hit aliases at every combination of the seven dropped bits. It can also land unaligned word accesses on the last bytes of a group, and run back-to-back accesses that flip the mode between them.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
    localparam int SZ_W = 3;

    localparam logic [SZ_W-1:0] SZ_BYTE = 3'd1;
    localparam logic [SZ_W-1:0] SZ_HALF = 3'd2;
    localparam logic [SZ_W-1:0] SZ_WORD = 3'd4;

    typedef enum logic {
        MAP_FLAT   = 1'b0,
        MAP_SPARSE = 1'b1
    } map_mode_e;
endpackage

// File: rtl/iowin_addr_map.sv
module iowin_addr_map #(
    parameter int SPAN_LOG2  = 23,
    parameter int PAGE_LOG2  = 12,
    parameter int GROUP_LOG2 = 5,
    parameter int IO_AW      = 16
) (
    input  logic [SPAN_LOG2-1:0] off,
    input  logic                 sparse,
    output logic [IO_AW-1:0]     addr
);
    import iowin_pkg::*;

    localparam int HI_W = SPAN_LOG2 - PAGE_LOG2;

    logic [IO_AW-1:0] flat_addr;
    logic [IO_AW-1:0] sparse_addr;
    logic             unused_mid;
    map_mode_e        mode;

    // page number becomes the high part, group-internal offset is kept
    assign sparse_addr = {off[SPAN_LOG2-1:PAGE_LOG2], off[GROUP_LOG2-1:0]};
    assign flat_addr   = off[IO_AW-1:0];
    assign unused_mid  = ^off[PAGE_LOG2-1:GROUP_LOG2];
    assign mode        = map_mode_e'(sparse);

    always_comb begin
        unique case (mode)
            MAP_SPARSE: addr = sparse_addr;
            default:    addr = flat_addr;
        endcase
    end

    initial begin
        if (HI_W + GROUP_LOG2 != IO_AW) begin
            $display("iowin_addr_map: sparse width does not match IO_AW");
        end
    end
endmodule

// File: rtl/iowin_size_dec.sv
module iowin_size_dec #(
    parameter int NBYTES = 4
) (
    input  logic [iowin_pkg::SZ_W-1:0] size,
    output logic                       legal,
    output logic [NBYTES-1:0]          be
);
    import iowin_pkg::*;

    assign legal = (size == SZ_BYTE) || (size == SZ_HALF) || (size == SZ_WORD);

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign be[i] = legal && (size > SZ_W'(i));
    end
endmodule

// File: rtl/iowin_lane_mask.sv
module iowin_lane_mask #(
    parameter int NBYTES = 4
) (
    input  logic [8*NBYTES-1:0] din,
    input  logic [NBYTES-1:0]   be,
    output logic [8*NBYTES-1:0] dout
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign dout[8*i +: 8] = be[i] ? din[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate #(
    parameter int              ADDR_W     = 32,
    parameter int              DATA_W     = 32,
    parameter int              IO_AW      = 16,
    parameter int              SPAN_LOG2  = 23,
    parameter int              PAGE_LOG2  = 12,
    parameter int              GROUP_LOG2 = 5,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [2:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              sparse_mode,
    output logic              io_valid,
    output logic              io_we,
    output logic [IO_AW-1:0]  io_addr,
    output logic [2:0]        io_size,
    output logic [DATA_W-1:0] io_wdata,
    output logic              io_err,
    input  logic              io_rvalid,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              cpu_rready,
    output logic [DATA_W-1:0] cpu_rdata
);
    import iowin_pkg::*;

    localparam int NBYTES = DATA_W / 8;

    typedef struct packed {
        logic              vld;
        logic              we;
        logic              err;
        logic [IO_AW-1:0]  addr;
        logic [SZ_W-1:0]   size;
        logic [DATA_W-1:0] wdata;
        logic [NBYTES-1:0] rd_be;
        logic              rrdy;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [SPAN_LOG2-1:0] off;
    logic [IO_AW-1:0]     map_addr;
    logic                 size_ok;
    logic [NBYTES-1:0]    req_be;
    logic [DATA_W-1:0]    wdata_m;
    logic [DATA_W-1:0]    rdata_m;

    assign off = SPAN_LOG2'(cpu_addr - WIN_BASE);

    iowin_addr_map #(
        .SPAN_LOG2 (SPAN_LOG2),
        .PAGE_LOG2 (PAGE_LOG2),
        .GROUP_LOG2(GROUP_LOG2),
        .IO_AW     (IO_AW)
    ) u_map (
        .off   (off),
        .sparse(sparse_mode),
        .addr  (map_addr)
    );

    iowin_size_dec #(.NBYTES(NBYTES)) u_size (
        .size (cpu_size),
        .legal(size_ok),
        .be   (req_be)
    );

    iowin_lane_mask #(.NBYTES(NBYTES)) u_wmask (
        .din (cpu_wdata),
        .be  (req_be),
        .dout(wdata_m)
    );

    iowin_lane_mask #(.NBYTES(NBYTES)) u_rmask (
        .din (io_rdata),
        .be  (st_q.rd_be),
        .dout(rdata_m)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = cpu_req && size_ok;
        st_d.err  = cpu_req && !size_ok;
        st_d.rrdy = io_rvalid;
        if (cpu_req && size_ok) begin
            st_d.we    = cpu_we;
            st_d.addr  = map_addr;
            st_d.size  = cpu_size;
            st_d.wdata = wdata_m;
            if (!cpu_we) begin
                st_d.rd_be = req_be;
            end
        end
        if (io_rvalid) begin
            st_d.rdata = rdata_m;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_valid   = st_q.vld;
    assign io_we      = st_q.we;
    assign io_addr    = st_q.addr;
    assign io_size    = st_q.size;
    assign io_wdata   = st_q.wdata;
    assign io_err     = st_q.err;
    assign cpu_rready = st_q.rrdy;
    assign cpu_rdata  = st_q.rdata;
endmodule

// File: rtl/iowin_xlate_chk.sv
module iowin_xlate_chk #(
    parameter int              ADDR_W     = 32,
    parameter int              DATA_W     = 32,
    parameter int              IO_AW      = 16,
    parameter int              SPAN_LOG2  = 23,
    parameter int              PAGE_LOG2  = 12,
    parameter int              GROUP_LOG2 = 5,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [2:0]        cpu_size,
    input logic              sparse_mode,
    input logic              io_valid,
    input logic [IO_AW-1:0]  io_addr,
    input logic [2:0]        io_size,
    input logic [DATA_W-1:0] io_wdata,
    input logic              io_err,
    input logic              io_rvalid,
    input logic              cpu_rready
);
    logic [SPAN_LOG2-1:0] off_c;
    assign off_c = SPAN_LOG2'(cpu_addr - WIN_BASE);

    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_valid && io_err));                                            // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_req) |-> (!io_valid && !io_err));                       // R11
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> (io_size == 3'd1 || io_size == 3'd2 || io_size == 3'd4)); // R6
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_err |-> !($past(cpu_size) == 3'd1 || $past(cpu_size) == 3'd2 ||
                     $past(cpu_size) == 3'd4));                            // R7
    AST_FLAT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !$past(sparse_mode)) |-> io_addr == $past(off_c[IO_AW-1:0])); // R2
    AST_SPARSE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && $past(sparse_mode)) |->
        io_addr == {$past(off_c[SPAN_LOG2-1:PAGE_LOG2]), $past(off_c[GROUP_LOG2-1:0])}); // R3
    AST_BYTE_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_size == 3'd1) |-> (io_wdata >> 8) == '0);          // R9
    AST_RREADY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rready |-> $past(io_rvalid));                                  // R10
endmodule

bind iowin_xlate iowin_xlate_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IO_AW     (IO_AW),
    .SPAN_LOG2 (SPAN_LOG2),
    .PAGE_LOG2 (PAGE_LOG2),
    .GROUP_LOG2(GROUP_LOG2),
    .WIN_BASE  (WIN_BASE)
) u_chk (.*);

// File: tb/sim_iowin_xlate.sv
module sim_iowin_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [2:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        sparse_mode = 1'b0;
    logic        io_valid, io_we, io_err, cpu_rready;
    logic [15:0] io_addr;
    logic [2:0]  io_size;
    logic [31:0] io_wdata, cpu_rdata;
    logic        io_rvalid = 1'b0;
    logic [31:0] io_rdata = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    iowin_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .sparse_mode(sparse_mode), .io_valid(io_valid), .io_we(io_we),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_err(io_err), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .cpu_rready(cpu_rready), .cpu_rdata(cpu_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] zext(input logic [31:0] d, input int sz);
        if (sz == 1) return d & 32'h0000_00ff;
        if (sz == 2) return d & 32'h0000_ffff;
        if (sz == 4) return d;
        return 32'h0;
    endfunction

    function automatic logic [15:0] ref_map(input logic [31:0] a, input bit sp);
        longint o = longint'(a) - longint'(32'h8000_0000);
        if (sp) return 16'(((o / 4096) % 2048) * 32 + (o % 32));
        return 16'(o % 65536);
    endfunction

    // behavioural reference: expected outputs for the next cycle
    bit          e_vld, e_err, e_we, e_rrdy, e_sp;
    logic [15:0] e_addr;
    int          e_size, m_rsz;
    logic [31:0] e_wdata, e_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_vld = 0; e_err = 0; e_rrdy = 0; e_we = 0; e_sp = 0;
            e_addr = '0; e_size = 0; e_wdata = '0; e_rdata = '0; m_rsz = 0;
        end else begin
            bit legal;
            e_rrdy = io_rvalid;
            if (io_rvalid) e_rdata = zext(io_rdata, m_rsz);
            legal = (cpu_size == 1 || cpu_size == 2 || cpu_size == 4);
            e_vld = cpu_req && legal;
            e_err = cpu_req && !legal;
            if (e_vld) begin
                e_addr = ref_map(cpu_addr, sparse_mode);
                e_sp = sparse_mode;
                e_size = int'(cpu_size);
                e_we = cpu_we;
                e_wdata = zext(cpu_wdata, int'(cpu_size));
                if (!cpu_we) m_rsz = int'(cpu_size);
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            chk("R6/R11 io_valid", 32'(io_valid), 32'(e_vld));
            chk("R7/R11 io_err", 32'(io_err), 32'(e_err));
            chk("R10 cpu_rready", 32'(cpu_rready), 32'(e_rrdy));
            if (e_vld) begin
                chk(e_sp ? "R3 io_addr" : "R2 io_addr", 32'(io_addr), 32'(e_addr));
                chk("R6 io_size", 32'(io_size), 32'(e_size));
                chk("R6 io_we", 32'(io_we), 32'(e_we));
                chk("R9 io_wdata", io_wdata, e_wdata);
            end
            if (e_rrdy) chk("R10 cpu_rdata", cpu_rdata, e_rdata);
        end
        if (cyc > 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic acc(input logic [31:0] off, input logic [2:0] sz, input bit we,
                       input logic [31:0] wd, input bit sp);
        cpu_req = 1; cpu_addr = 32'h8000_0000 + off; cpu_size = sz;
        cpu_we = we; cpu_wdata = wd; sparse_mode = sp;
        @(negedge clk);
        cpu_req = 0;
    endtask

    task automatic idle(input int n);
        cpu_req = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic respond(input logic [31:0] d);
        io_rvalid = 1; io_rdata = d;
        @(negedge clk);
        io_rvalid = 0;
    endtask

    initial begin
        logic [15:0] a0;
        repeat (3) @(negedge clk);
        chk("R1 io_valid in reset", 32'(io_valid), 32'h0);
        chk("R1 cpu_rready in reset", 32'(cpu_rready), 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 io_err after reset", 32'(io_err), 32'h0);
        chk("R1 io_valid after reset", 32'(io_valid), 32'h0);

        // flat mode, several patterns, R2 / R6 / R9
        acc(32'h0000_03f8, 3'd1, 1, 32'hdead_beef, 0);
        chk("R2 flat addr", 32'(io_addr), 32'h03f8);
        chk("R9 byte lane", io_wdata, 32'h0000_00ef);
        acc(32'h0012_cf8c, 3'd2, 1, 32'h1234_5678, 0);
        chk("R2 flat high bits dropped", 32'(io_addr), 32'hcf8c);
        acc(32'h007f_ffff, 3'd4, 0, 32'h0, 0);
        idle(1);

        // sparse mode, R3 at the top of the span
        acc(32'h007f_f01f, 3'd1, 0, 32'h0, 1);
        chk("R3 sparse top", 32'(io_addr), 32'hffff);
        acc(32'h0000_1003, 3'd2, 1, 32'haabb_ccdd, 1);
        chk("R3 sparse page1", 32'(io_addr), 32'h0023);

        // R4 aliases over bits 11:5
        acc(32'h0034_5011, 3'd1, 0, 32'h0, 1);
        a0 = io_addr;
        for (int k = 1; k < 128; k += 9) begin
            acc(32'h0034_5011 | (32'(k) << 5), 3'd1, 0, 32'h0, 1);
            chk("R4 alias", 32'(io_addr), 32'(a0));
        end
        acc(32'h0034_5ff1, 3'd4, 0, 32'h0, 1);
        chk("R4 alias all ones", 32'(io_addr), 32'(a0));

        // R5 mode flips between back-to-back accesses
        acc(32'h0000_2044, 3'd4, 1, 32'h1, 1);
        chk("R5 sparse first", 32'(io_addr), 32'h0044);
        acc(32'h0000_2044, 3'd4, 1, 32'h1, 0);
        chk("R5 flat second", 32'(io_addr), 32'h2044);
        acc(32'h0000_2044, 3'd4, 1, 32'h1, 1);
        chk("R5 sparse third", 32'(io_addr), 32'h0044);

        // R8 unaligned
        acc(32'h0000_0003, 3'd4, 1, 32'hcafe_f00d, 0);
        chk("R8 unaligned flat", 32'(io_addr[1:0]), 32'h3);
        acc(32'h0000_301f, 3'd4, 1, 32'hcafe_f00d, 1);
        chk("R8 unaligned sparse", 32'(io_addr), 32'h007f);

        // R7 illegal sizes, each followed by a legal one
        for (int s = 0; s < 8; s++) begin
            acc(32'h0000_0100, 3'(s), 1, 32'h5555_aaaa, 0);
            if (s == 1 || s == 2 || s == 4) chk("R6 legal size", 32'(io_valid), 32'h1);
            else begin
                chk("R7 err raised", 32'(io_err), 32'h1);
                chk("R7 no transfer", 32'(io_valid), 32'h0);
            end
        end
        idle(1);
        chk("R11 quiet after idle", 32'(io_valid | io_err), 32'h0);

        // R10 read returns for each size
        acc(32'h0000_0060, 3'd1, 0, 32'h0, 0);
        respond(32'h8765_4321);
        chk("R10 byte read", cpu_rdata, 32'h0000_0021);
        acc(32'h0000_0062, 3'd2, 0, 32'h0, 0);
        acc(32'h0000_0064, 3'd3, 0, 32'h0, 0);
        respond(32'h8765_4321);
        chk("R10 half read, illegal ignored", cpu_rdata, 32'h0000_4321);
        acc(32'h0000_0068, 3'd4, 0, 32'h0, 1);
        acc(32'h0000_0068, 3'd1, 1, 32'hff, 1);
        respond(32'h8765_4321);
        chk("R10 word read", cpu_rdata, 32'h8765_4321);
        idle(1);
        chk("R10 rready one cycle", 32'(cpu_rready), 32'h0);

        // mixed back-to-back stream compared by the model
        for (int i = 0; i < 200; i++) begin
            acc(32'((i * 32'h0001_3579) & 32'h007f_ffff), 3'((i % 5) + 1),
                bit'(i % 3 == 0), 32'(i * 32'h0101_0303), bit'((i / 7) % 2));
            if (i % 11 == 0) respond(32'(i * 32'h1357_9bdf));
        end
        idle(3);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule